// File: doc/BRIEF.md
# Two-Bank SDRAM Command Front End

This block is the device-side front end of a two-bank synchronous DRAM model. On every rising clock edge at which the clock-enable input is high, it samples chip select, the three command strobes, the 12-bit address and the data mask. It turns them into one-cycle command pulses and keeps, for each bank, whether a row is open and which row that is. It also runs the data bursts that follow a read or a write, and drives a write-enable and a read output-enable shaped by the data mask.

Address bit 10 does two jobs. On a read or a write it asks for the addressed bank to be closed automatically when the burst ends. On a precharge it widens the close to both banks. The data mask acts at once during writes, where it blocks that cycle's data. During reads it takes effect two enabled clocks after it is sampled and gates the output drivers. The column width follows the data organisation parameter: 10, 9 or 8 bits for 4, 8 or 16 data bits.

All outputs are registers. A command sampled at an enabled edge shows on the outputs just after that same edge. The memory array, refresh counting and mode register contents live elsewhere.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset every output is low and both banks are closed.
- R2: With cs_n low, {ras_n,cas_n,we_n} is decoded as 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh, 000 mode register set, and 111 or 110 as no operation. The matching strobe is high for exactly the one cycle after the sampling edge, and at most one strobe (including cmd_illegal) is high at a time.
- R3: An activate opens the bank chosen by addr[11] (0 = bank A = bank_open[0], 1 = bank B = bank_open[1]) and stores addr[10:0] as that bank's row, shown on open_row[10:0] for bank A and open_row[21:11] for bank B.
- R4: An accepted read or write places addr[COL_W-1:0] on col_addr and addr[11] on col_bank, where COL_W is 10, 9 or 8 for ORG_BITS 4, 8 or 16.
- R5: A read or write to a closed bank pulses cmd_illegal, raises neither cmd_rd nor cmd_wr, and changes no bank, column or burst state.
- R6: A precharge with addr[10] high closes both banks whatever addr[11] is. With addr[10] low it closes only the bank that addr[11] names.
- R7: A read or write with addr[10] high closes its bank at the edge of its last burst beat. With addr[10] low the bank stays open.
- R8: A write burst has BURST_LEN beats, at the command edge and the following enabled edges. After each beat wr_en equals the inverse of dqm sampled at that same edge, and wr_data_q holds that edge's wr_data.
- R9: A read burst has BURST_LEN beats, at the BURST_LEN enabled edges after the command. After each beat rd_oe equals the inverse of dqm sampled two enabled edges earlier. Outside bursts, wr_en and rd_oe are low.
- R10: With cs_n high nothing new is decoded, whatever the other pins carry, and a burst in progress runs to its end.
- R11: A read or write accepted while a burst is running ends that burst at once, and a pending auto-close of the old burst takes effect at that edge.
- R12: At an edge where cke is low, no output and no internal state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable, low freezes the block |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Command strobe (row) |
| cas_n | input | 1 | Command strobe (column) |
| we_n | input | 1 | Command strobe (write) |
| addr | input | 12 | Row/column address, bit 10 auto/all-bank close, bit 11 bank |
| dqm | input | 1 | Data mask |
| wr_data | input | ORG_BITS | Write data beat |
| cmd_act | output | 1 | Activate accepted |
| cmd_rd | output | 1 | Read accepted |
| cmd_wr | output | 1 | Write accepted |
| cmd_pre | output | 1 | Precharge accepted |
| cmd_ref | output | 1 | Auto refresh accepted |
| cmd_mrs | output | 1 | Mode register set accepted |
| cmd_illegal | output | 1 | Read or write to a closed bank |
| bank_open | output | 2 | Open flag per bank |
| open_row | output | 22 | Stored row per bank |
| col_addr | output | COL_W | Column of the last accepted read/write |
| col_bank | output | 1 | Bank of the last accepted read/write |
| wr_en | output | 1 | Write strobe for the current beat |
| wr_data_q | output | ORG_BITS | Registered write data |
| rd_oe | output | 1 | Read output enable |

## Verification
A wrong open flag or stored row shows on bank_open and open_row just after the edge that set it. A later read or write then also pulses cmd_illegal when it should not, or the reverse. A wrong burst counter or auto-close flag shows as a wr_en or rd_oe beat that is one cycle long or short, or as a bank that closes at the wrong edge, within BURST_LEN cycles. A data-mask pipeline that is off by one stage shows on rd_oe at the first read beat that follows a change of dqm.

// File: rtl/sdram_fe_pkg.sv
`timescale 1ns/1ps
package sdram_fe_pkg;

   localparam int ADDR_W   = 12;
   localparam int ROW_W    = 11;
   localparam int AP_BIT   = 10;
   localparam int BANK_BIT = 11;
   localparam int NBANK    = 2;

   typedef enum logic [2:0] {
      OP_MRS  = 3'b000,
      OP_REF  = 3'b001,
      OP_PRE  = 3'b010,
      OP_ACT  = 3'b011,
      OP_WR   = 3'b100,
      OP_RD   = 3'b101,
      OP_STOP = 3'b110,
      OP_NOP  = 3'b111
   } op_e;

   // Column width follows the data organisation.
   function automatic int col_width(input int org_bits);
      case (org_bits)
         4:       return 10;
         8:       return 9;
         default: return 8;
      endcase
   endfunction

endpackage

// File: rtl/sdram_mask_pipe.sv
`timescale 1ns/1ps
module sdram_mask_pipe #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic mask_in,
   output logic mask_late
);

   generate
      if (LAT < 1) begin : g_bad
         $error("sdram_mask_pipe: LAT must be at least 1");
      end
   endgenerate

   logic [LAT-1:0] stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage <= '0;
      end else if (en) begin
         stage[0] <= mask_in;
         for (int i = 1; i < LAT; i++) begin
            stage[i] <= stage[i-1];
         end
      end
   end

   // Value sampled LAT enabled edges before the current one.
   assign mask_late = stage[LAT-1];

endmodule

// File: rtl/sdram_burst_ctrl.sv
`timescale 1ns/1ps
module sdram_burst_ctrl
   import sdram_fe_pkg::*;
#(
   parameter int BURST_LEN   = 4,
   parameter int DQ_W        = 4,
   parameter int RD_MASK_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             start_rd,
   input  logic             start_wr,
   input  logic             req_ap,
   input  logic             req_bank,
   input  logic             dqm,
   input  logic [DQ_W-1:0]  wr_data,
   output logic [NBANK-1:0] ap_close,
   output logic             wr_en,
   output logic [DQ_W-1:0]  wr_data_q,
   output logic             rd_oe
);

   localparam int CNT_W = $clog2(BURST_LEN + 1);
   localparam logic [CNT_W-1:0] LEN_C  = CNT_W'(BURST_LEN);
   localparam logic [CNT_W-1:0] LEN_M1 = CNT_W'(BURST_LEN - 1);
   localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

   logic [CNT_W-1:0] remain;
   logic             is_read;
   logic             ap_pend;
   logic             ap_bank;
   logic             mask_rd;
   logic             active;
   logic             start;
   logic             single_wr_ap;

   sdram_mask_pipe #(.LAT(RD_MASK_LAT)) u_mask (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .mask_in   (dqm),
      .mask_late (mask_rd)
   );

   assign active = (remain != '0);
   assign start  = start_rd | start_wr;

   // A write of one beat ends at its own command edge.
   generate
      if (BURST_LEN == 1) begin : g_single
         assign single_wr_ap = start_wr & req_ap;
      end else begin : g_multi
         assign single_wr_ap = 1'b0;
      end
   endgenerate

   // Auto-close of the running burst: on its last beat, or when a new
   // read/write cuts it short.
   always_comb begin
      ap_close = '0;
      if (active && ap_pend && (start || remain == ONE_C)) begin
         ap_close[ap_bank] = 1'b1;
      end
      if (single_wr_ap) begin
         ap_close[req_bank] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain    <= '0;
         is_read   <= 1'b0;
         ap_pend   <= 1'b0;
         ap_bank   <= 1'b0;
         wr_en     <= 1'b0;
         wr_data_q <= '0;
         rd_oe     <= 1'b0;
      end else if (en) begin
         if (start_wr) begin
            remain    <= LEN_M1;
            is_read   <= 1'b0;
            ap_pend   <= req_ap;
            ap_bank   <= req_bank;
            wr_en     <= ~dqm;
            wr_data_q <= wr_data;
            rd_oe     <= 1'b0;
         end else if (start_rd) begin
            remain    <= LEN_C;
            is_read   <= 1'b1;
            ap_pend   <= req_ap;
            ap_bank   <= req_bank;
            wr_en     <= 1'b0;
            rd_oe     <= 1'b0;
         end else if (active) begin
            remain <= remain - ONE_C;
            if (is_read) begin
               rd_oe <= ~mask_rd;
               wr_en <= 1'b0;
            end else begin
               wr_en     <= ~dqm;
               wr_data_q <= wr_data;
               rd_oe     <= 1'b0;
            end
         end else begin
            wr_en <= 1'b0;
            rd_oe <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sdram_cmd_decode.sv
`timescale 1ns/1ps
module sdram_cmd_decode
   import sdram_fe_pkg::*;
(
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NBANK-1:0]  bank_open,
   output logic              go_act,
   output logic              go_rd,
   output logic              go_wr,
   output logic              go_pre,
   output logic              go_ref,
   output logic              go_mrs,
   output logic              go_illegal,
   output logic [NBANK-1:0]  act_sel,
   output logic [NBANK-1:0]  pre_sel,
   output logic              tgt_bank,
   output logic              ap_flag
);

   op_e  op;
   logic sel;
   logic tgt_open;
   logic is_rw;
   logic [NBANK-1:0] one_hot;

   assign op       = op_e'({ras_n, cas_n, we_n});
   assign sel      = ~cs_n;
   assign tgt_bank = addr[BANK_BIT];
   assign ap_flag  = addr[AP_BIT];
   assign tgt_open = bank_open[tgt_bank];
   assign one_hot  = tgt_bank ? 2'b10 : 2'b01;
   assign is_rw    = sel && (op == OP_RD || op == OP_WR);

   assign go_act     = sel && (op == OP_ACT);
   assign go_rd      = sel && (op == OP_RD) && tgt_open;
   assign go_wr      = sel && (op == OP_WR) && tgt_open;
   assign go_pre     = sel && (op == OP_PRE);
   assign go_ref     = sel && (op == OP_REF);
   assign go_mrs     = sel && (op == OP_MRS);
   assign go_illegal = is_rw && !tgt_open;

   assign act_sel = go_act ? one_hot : '0;
   assign pre_sel = go_pre ? (ap_flag ? '1 : one_hot) : '0;

endmodule

// File: rtl/sdram_bank_track.sv
`timescale 1ns/1ps
module sdram_bank_track
   import sdram_fe_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic [NBANK-1:0]       act_sel,
   input  logic [NBANK-1:0]       close_sel,
   input  logic [ROW_W-1:0]       row_in,
   output logic [NBANK-1:0]       bank_open,
   output logic [NBANK*ROW_W-1:0] open_row
);

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bank_open[b]                 <= 1'b0;
               open_row[b*ROW_W +: ROW_W]   <= '0;
            end else if (en) begin
               if (act_sel[b]) begin
                  bank_open[b]               <= 1'b1;
                  open_row[b*ROW_W +: ROW_W] <= row_in;
               end else if (close_sel[b]) begin
                  bank_open[b] <= 1'b0;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sdram_cmd_front.sv
`timescale 1ns/1ps
module sdram_cmd_front
   import sdram_fe_pkg::*;
#(
   parameter int ORG_BITS    = 4,
   parameter int BURST_LEN   = 4,
   parameter int RD_MASK_LAT = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  cke,
   input  logic                                  cs_n,
   input  logic                                  ras_n,
   input  logic                                  cas_n,
   input  logic                                  we_n,
   input  logic [ADDR_W-1:0]                     addr,
   input  logic                                  dqm,
   input  logic [ORG_BITS-1:0]                   wr_data,
   output logic                                  cmd_act,
   output logic                                  cmd_rd,
   output logic                                  cmd_wr,
   output logic                                  cmd_pre,
   output logic                                  cmd_ref,
   output logic                                  cmd_mrs,
   output logic                                  cmd_illegal,
   output logic [NBANK-1:0]                      bank_open,
   output logic [NBANK*ROW_W-1:0]                open_row,
   output logic [col_width(ORG_BITS)-1:0]        col_addr,
   output logic                                  col_bank,
   output logic                                  wr_en,
   output logic [ORG_BITS-1:0]                   wr_data_q,
   output logic                                  rd_oe
);

   localparam int COL_W = col_width(ORG_BITS);

   generate
      if (!(ORG_BITS == 4 || ORG_BITS == 8 || ORG_BITS == 16)) begin : g_bad_org
         $error("sdram_cmd_front: ORG_BITS must be 4, 8 or 16");
      end
      if (!(BURST_LEN == 1 || BURST_LEN == 2 || BURST_LEN == 4 || BURST_LEN == 8)) begin : g_bad_bl
         $error("sdram_cmd_front: BURST_LEN must be 1, 2, 4 or 8");
      end
      if (COL_W > AP_BIT) begin : g_bad_col
         $error("sdram_cmd_front: column field overlaps the auto-close bit");
      end
   endgenerate

   logic             en;
   logic             go_act, go_rd, go_wr, go_pre, go_ref, go_mrs, go_illegal;
   logic [NBANK-1:0] act_sel, pre_sel, ap_close, close_sel;
   logic             tgt_bank, ap_flag;

   assign en = cke;

   sdram_cmd_decode u_dec (
      .cs_n       (cs_n),
      .ras_n      (ras_n),
      .cas_n      (cas_n),
      .we_n       (we_n),
      .addr       (addr),
      .bank_open  (bank_open),
      .go_act     (go_act),
      .go_rd      (go_rd),
      .go_wr      (go_wr),
      .go_pre     (go_pre),
      .go_ref     (go_ref),
      .go_mrs     (go_mrs),
      .go_illegal (go_illegal),
      .act_sel    (act_sel),
      .pre_sel    (pre_sel),
      .tgt_bank   (tgt_bank),
      .ap_flag    (ap_flag)
   );

   sdram_burst_ctrl #(
      .BURST_LEN   (BURST_LEN),
      .DQ_W        (ORG_BITS),
      .RD_MASK_LAT (RD_MASK_LAT)
   ) u_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .start_rd  (go_rd),
      .start_wr  (go_wr),
      .req_ap    (ap_flag),
      .req_bank  (tgt_bank),
      .dqm       (dqm),
      .wr_data   (wr_data),
      .ap_close  (ap_close),
      .wr_en     (wr_en),
      .wr_data_q (wr_data_q),
      .rd_oe     (rd_oe)
   );

   assign close_sel = pre_sel | ap_close;

   sdram_bank_track u_banks (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .act_sel   (act_sel),
      .close_sel (close_sel),
      .row_in    (addr[ROW_W-1:0]),
      .bank_open (bank_open),
      .open_row  (open_row)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_act     <= 1'b0;
         cmd_rd      <= 1'b0;
         cmd_wr      <= 1'b0;
         cmd_pre     <= 1'b0;
         cmd_ref     <= 1'b0;
         cmd_mrs     <= 1'b0;
         cmd_illegal <= 1'b0;
         col_addr    <= '0;
         col_bank    <= 1'b0;
      end else if (en) begin
         cmd_act     <= go_act;
         cmd_rd      <= go_rd;
         cmd_wr      <= go_wr;
         cmd_pre     <= go_pre;
         cmd_ref     <= go_ref;
         cmd_mrs     <= go_mrs;
         cmd_illegal <= go_illegal;
         if (go_rd || go_wr) begin
            col_addr <= addr[COL_W-1:0];
            col_bank <= tgt_bank;
         end
      end
   end

endmodule

// File: rtl/sdram_cmd_front_chk.sv
`timescale 1ns/1ps
module sdram_cmd_front_chk
   import sdram_fe_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic              cmd_act,
   input logic              cmd_rd,
   input logic              cmd_wr,
   input logic              cmd_pre,
   input logic              cmd_ref,
   input logic              cmd_mrs,
   input logic              cmd_illegal,
   input logic [NBANK-1:0]  bank_open,
   input logic              wr_en,
   input logic              rd_oe
);

   logic [2:0] op_bits;
   logic       any_strobe;
   assign op_bits    = {ras_n, cas_n, we_n};
   assign any_strobe = cmd_act | cmd_rd | cmd_wr | cmd_pre | cmd_ref | cmd_mrs | cmd_illegal;

   // R2
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_illegal}));

   // R10
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && cs_n) |=> !any_strobe);

   // R3
   act_opens_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !cs_n && op_bits == 3'b011 && !addr[BANK_BIT]) |=> bank_open[0]);

   // R3
   act_opens_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !cs_n && op_bits == 3'b011 && addr[BANK_BIT]) |=> bank_open[1]);

   // R5
   closed_bank_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !cs_n && (op_bits == 3'b101 || op_bits == 3'b100) && !bank_open[addr[BANK_BIT]])
      |=> (cmd_illegal && !cmd_rd && !cmd_wr));

   // R6
   pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !cs_n && op_bits == 3'b010 && addr[AP_BIT]) |=> (bank_open == 2'b00));

   // R12
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> ($stable(bank_open) && $stable(wr_en) && $stable(rd_oe) && $stable(any_strobe)));

   // R9
   rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_oe));

endmodule

bind sdram_cmd_front sdram_cmd_front_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cke         (cke),
   .cs_n        (cs_n),
   .ras_n       (ras_n),
   .cas_n       (cas_n),
   .we_n        (we_n),
   .addr        (addr),
   .cmd_act     (cmd_act),
   .cmd_rd      (cmd_rd),
   .cmd_wr      (cmd_wr),
   .cmd_pre     (cmd_pre),
   .cmd_ref     (cmd_ref),
   .cmd_mrs     (cmd_mrs),
   .cmd_illegal (cmd_illegal),
   .bank_open   (bank_open),
   .wr_en       (wr_en),
   .rd_oe       (rd_oe)
);

// File: tb/tb_sdram_cmd_front.sv
`timescale 1ns/1ps
module tb_sdram_cmd_front;

   localparam int ORG = 4;
   localparam int BL  = 4;
   localparam int CW  = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [11:0] addr = '0;
   logic dqm = 1'b0;
   logic [ORG-1:0] wr_data = '0;

   logic cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_illegal;
   logic [1:0] bank_open;
   logic [21:0] open_row;
   logic [CW-1:0] col_addr;
   logic col_bank, wr_en, rd_oe;
   logic [ORG-1:0] wr_data_q;

   always #5 clk = ~clk;

   sdram_cmd_front #(.ORG_BITS(ORG), .BURST_LEN(BL), .RD_MASK_LAT(2)) dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .addr(addr), .dqm(dqm), .wr_data(wr_data),
      .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
      .cmd_ref(cmd_ref), .cmd_mrs(cmd_mrs), .cmd_illegal(cmd_illegal),
      .bank_open(bank_open), .open_row(open_row), .col_addr(col_addr),
      .col_bank(col_bank), .wr_en(wr_en), .wr_data_q(wr_data_q), .rd_oe(rd_oe)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;
   string tag = "R1";

   // Reference model state
   int m_rem = 0;
   bit m_isrd = 0, m_ap = 0;
   int m_apb = 0;
   bit [1:0] m_open = 0;
   logic [10:0] m_row [2] = '{11'h0, 11'h0};
   bit dq_hist[$];
   bit [6:0] e_str = 0;  // act, rd, wr, pre, ref, mrs, illegal
   logic [CW-1:0] e_col = '0;
   bit e_colb = 0, e_wen = 0, e_oe = 0;
   logic [ORG-1:0] e_wd = '0;

   localparam bit [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100, C_PRE = 3'b010,
                        C_REF = 3'b001, C_MRS = 3'b000, C_NOP = 3'b111, C_STP = 3'b110;

   task automatic model(input bit ke, input bit cs, input bit [2:0] cmd,
                        input logic [11:0] a, input bit dm, input logic [ORG-1:0] wd);
      int b;
      bit dm2;
      bit new_rd, new_wr;
      bit [1:0] clr;
      if (!ke) return;
      b = int'(a[11]);
      dm2 = (dq_hist.size() >= 2) ? dq_hist[dq_hist.size()-2] : 1'b0;
      dq_hist.push_back(dm);
      if (dq_hist.size() > 4) void'(dq_hist.pop_front());
      e_str = 0;
      new_rd = 0; new_wr = 0; clr = 0;
      if (!cs) begin
         case (cmd)
            C_ACT: e_str[6] = 1;
            C_RD:  if (m_open[b]) begin e_str[5] = 1; new_rd = 1; end else e_str[0] = 1;
            C_WR:  if (m_open[b]) begin e_str[4] = 1; new_wr = 1; end else e_str[0] = 1;
            C_PRE: e_str[3] = 1;
            C_REF: e_str[2] = 1;
            C_MRS: e_str[1] = 1;
            default: ;
         endcase
      end
      if (m_rem > 0 && m_ap && (new_rd || new_wr || m_rem == 1)) clr[m_apb] = 1;
      if (new_wr) begin
         e_wen = !dm; e_wd = wd; e_oe = 0;
         m_rem = BL - 1; m_isrd = 0; m_ap = a[10]; m_apb = b;
         if (BL == 1 && a[10]) clr[b] = 1;
      end else if (new_rd) begin
         e_wen = 0; e_oe = 0;
         m_rem = BL; m_isrd = 1; m_ap = a[10]; m_apb = b;
      end else if (m_rem > 0) begin
         if (m_isrd) begin e_oe = !dm2; e_wen = 0; end
         else begin e_wen = !dm; e_wd = wd; e_oe = 0; end
         m_rem--;
      end else begin
         e_wen = 0; e_oe = 0;
      end
      if (e_str[3]) begin
         if (a[10]) clr = 2'b11; else clr[b] = 1;
      end
      m_open = m_open & ~clr;
      if (e_str[6]) begin m_open[b] = 1; m_row[b] = a[10:0]; end
      if (new_rd || new_wr) begin e_col = a[CW-1:0]; e_colb = a[11]; end
   endtask

   task automatic chk(input string what, input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("strobes", (tag == "R1") ? "R1" : "R2",
          {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_illegal}, e_str);
      chk("illegal", "R5", cmd_illegal, e_str[0]);
      chk("bank_open", (tag == "R7" || tag == "R11") ? tag : "R6", bank_open, m_open);
      chk("open_row", "R3", open_row, {m_row[1], m_row[0]});
      chk("col_addr", "R4", col_addr, e_col);
      chk("col_bank", "R4", col_bank, e_colb);
      chk("wr_en", (tag == "R12") ? "R12" : "R8", wr_en, e_wen);
      chk("wr_data_q", "R8", wr_data_q, e_wd);
      chk("rd_oe", (tag == "R10") ? "R10" : "R9", rd_oe, e_oe);
      if (tag != "R1" && tag != "R2" && tag != "R5")
         chk("scenario", tag, 0, 0);
   endtask

   task automatic cyc(input bit ke, input bit cs, input bit [2:0] cmd,
                      input logic [11:0] a, input bit dm, input logic [ORG-1:0] wd);
      cke = ke; cs_n = cs; {ras_n, cas_n, we_n} = cmd; addr = a; dqm = dm; wr_data = wd;
      model(ke, cs, cmd, a, dm, wd);
      @(posedge clk);
      #2;
      compare_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1, 1, C_NOP, 12'h000, 0, '0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      #1;
      // R1: reset state
      tag = "R1";
      compare_all();

      // R5: read/write to closed banks
      tag = "R5";
      cyc(1, 0, C_RD, 12'h013, 0, '0);
      cyc(1, 0, C_WR, 12'h821, 0, 4'h3);

      // R3: open both banks with distinct rows
      tag = "R3";
      cyc(1, 0, C_ACT, 12'h5A3, 0, '0);
      cyc(1, 0, C_ACT, 12'h9FF, 0, '0);

      // R8 / R4: write burst to bank A, mask on second beat
      tag = "R8";
      cyc(1, 0, C_WR, 12'h2C5, 0, 4'hA);
      cyc(1, 1, C_NOP, 12'h000, 1, 4'h5);
      cyc(1, 1, C_NOP, 12'h000, 0, 4'hC);
      cyc(1, 1, C_NOP, 12'h000, 0, 4'h7);
      idle(1);

      // R9: read from bank B, mask high one edge after command
      tag = "R9";
      cyc(1, 0, C_RD, 12'h8F1, 0, '0);
      cyc(1, 1, C_NOP, 12'h000, 1, '0);
      cyc(1, 1, C_NOP, 12'h000, 0, '0);
      cyc(1, 1, C_NOP, 12'h000, 1, '0);
      cyc(1, 1, C_NOP, 12'h000, 0, '0);
      idle(2);

      // R10: deselected pins carry an activate pattern during a read burst
      tag = "R10";
      cyc(1, 0, C_RD, 12'h0F0, 0, '0);
      cyc(1, 1, C_ACT, 12'h800, 0, '0);
      cyc(1, 1, C_PRE, 12'hC00, 0, '0);
      cyc(1, 1, C_WR, 12'h055, 0, '0);
      cyc(1, 1, C_MRS, 12'h000, 0, '0);
      idle(2);

      // R7: read with auto-close on bank B, then write with auto-close on bank A
      tag = "R7";
      cyc(1, 0, C_RD, 12'hC44, 0, '0);
      idle(BL + 1);
      cyc(1, 0, C_WR, 12'h433, 0, 4'h1);
      idle(BL + 1);

      // R12: freeze in the middle of a write burst
      tag = "R12";
      cyc(1, 0, C_ACT, 12'h111, 0, '0);
      cyc(1, 0, C_WR, 12'h0AB, 0, 4'h9);
      cyc(0, 0, C_PRE, 12'hC00, 1, 4'h2);
      cyc(0, 0, C_ACT, 12'h8FF, 0, 4'h4);
      cyc(0, 1, C_NOP, 12'h000, 1, 4'h6);
      cyc(1, 1, C_NOP, 12'h000, 1, 4'hE);
      cyc(1, 1, C_NOP, 12'h000, 0, 4'hD);
      cyc(1, 1, C_NOP, 12'h000, 0, 4'hB);
      idle(1);

      // R6: single-bank and all-bank precharge
      tag = "R6";
      cyc(1, 0, C_ACT, 12'h822, 0, '0);
      cyc(1, 0, C_PRE, 12'h000, 0, '0);
      cyc(1, 0, C_ACT, 12'h033, 0, '0);
      cyc(1, 0, C_PRE, 12'h400, 0, '0);
      cyc(1, 0, C_ACT, 12'h044, 0, '0);
      cyc(1, 0, C_ACT, 12'h855, 0, '0);
      cyc(1, 0, C_PRE, 12'h800, 0, '0);
      cyc(1, 0, C_PRE, 12'h000, 0, '0);

      // R11: write with auto-close cut short by a read to the other bank
      tag = "R11";
      cyc(1, 0, C_ACT, 12'h066, 0, '0);
      cyc(1, 0, C_ACT, 12'h877, 0, '0);
      cyc(1, 0, C_WR, 12'h412, 0, 4'h8);
      cyc(1, 0, C_RD, 12'h934, 1, '0);
      idle(BL + 2);

      // R2: remaining opcodes, including both no-op codes
      tag = "R2";
      cyc(1, 0, C_REF, 12'h000, 0, '0);
      cyc(1, 0, C_MRS, 12'h023, 0, '0);
      cyc(1, 0, C_NOP, 12'h000, 0, '0);
      cyc(1, 0, C_STP, 12'h000, 0, '0);
      cyc(1, 0, C_RD, 12'h8AA, 0, '0);
      idle(BL + 2);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule